// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block collects up to 64 peripheral interrupt lines and tells the processor which one to service next. Each line has an enable bit, a pending bit and a priority level, all held in a small register file behind a word-addressed write/read port. A rising edge on a line latches its pending bit. On every cycle an arbiter looks at the lines that are both enabled and pending and picks a single winner. The block then presents a request flag, the winner's vector number and the winner's priority byte on registered outputs.

Software changes enable and pending state through separate set and clear banks. A write of 1 to a bit acts on that line only, and a write of 0 has no effect, so no read-modify-write is needed. Priorities sit four to a word, one byte per vector. Only the top three bits of each byte are kept. A hold input stops delivery to the core and leaves every enable bit as it is. When the core acknowledges a delivered request, the block clears the pending bit of the vector it delivered.

Vector numbers 0 to 15 are left for processor exceptions, so peripheral line k is reported as vector k+16.

Top module: `prio_irq_ctrl`

## Requirements
- R1: A write to enable-set bank b (word address 0x00+b) sets enable bit 32*b+i for every 1 in bit i of the data. Bits written as 0 are left unchanged.
- R2: A write to enable-clear bank b (word address 0x08+b) clears enable bit 32*b+i for every 1 in bit i of the data. Bits written as 0 are left unchanged.
- R3: Pending-set bank b (0x10+b) and pending-clear bank b (0x18+b) act on pending bits in the same way as R1 and R2. A read of either the set bank or the clear bank of a group returns that group's current state. Read data appears on reg_rdata one cycle after the address is presented.
- R4: A 0-to-1 transition on irq_in[k] sets pending bit k. A line that stays high does not set its pending bit again after the bit has been cleared.
- R5: Line k is reported as vector k+16. While irq_req is 1, irq_vec is always in the range 16 to 16+N_LINES-1. A change of enable or pending state shows on the outputs at the second clock edge after it.
- R6: The priority byte of vector v is at word address 0x20+v/4, bits 8*(v mod 4)+7 down to 8*(v mod 4). Only the top 3 bits of the byte are stored, and the lower 5 bits read as 0. Bytes of vectors 0 to 15 read as 0 and ignore writes.
- R7: Among the lines that are enabled and pending, the one with the numerically smallest stored priority wins. When priorities are equal, the lower vector number wins. irq_prio reports the winner's priority byte.
- R8: A line that is pending but not enabled stays pending and is not delivered. It is delivered once it is enabled. irq_req is never 1 unless some line was both enabled and pending on the cycle before.
- R9: Clearing a pending bit before the line is enabled discards that request.
- R10: While deliver_hold is 1, irq_req is 0 from the next cycle on. The hold does not alter any enable bit.
- R11: When irq_ack is 1 while irq_req is 1, the pending bit of the delivered vector is cleared, and irq_req is 0 on the following cycle.
- R12: After reset, all enable, pending and priority state is 0, irq_req is 0 and irq_vec is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | N_LINES | Peripheral interrupt lines, rising-edge sensitive |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data for reg_addr |
| deliver_hold | input | 1 | Blocks delivery of the request to the core |
| irq_ack | input | 1 | Core acknowledges the delivered vector |
| irq_req | output | 1 | Request to the core |
| irq_vec | output | VEC_W | Winning vector number |
| irq_prio | output | 8 | Priority byte of the winning vector |

## Verification
The checker holds four rules on every cycle: the hold input suppresses the request on the next cycle, an acknowledge drops the request on the next cycle, a request never appears without an enabled and pending line behind it, and a delivered vector number always lies in the peripheral range. The bench scenarios cover what no single-cycle rule can show. These are the order in which winners are picked under different priority and tie patterns, the set and clear semantics of the banks, the truncation of the priority bytes, and the fate of requests that are held, discarded or latched while a line is disabled.

// File: rtl/pic_pkg.sv
package pic_pkg;
  localparam int unsigned REG_AW      = 8;
  localparam int unsigned REG_DW      = 32;
  localparam int unsigned VEC_BASE    = 16;
  localparam int unsigned BANK_STRIDE = 8;
  // group g of banks lives at g*BANK_STRIDE; priority words after the groups
  localparam int unsigned PRIO_BASE   = 4 * BANK_STRIDE;

  typedef enum logic [2:0] {
    RK_NONE   = 3'd0,
    RK_EN_SET = 3'd1,
    RK_EN_CLR = 3'd2,
    RK_PD_SET = 3'd3,
    RK_PD_CLR = 3'd4,
    RK_PRIO   = 3'd5
  } reg_kind_e;
endpackage

// File: rtl/pic_regdec.sv
module pic_regdec
  import pic_pkg::*;
#(
  parameter int unsigned N_LINES = 64
) (
  input  logic [REG_AW-1:0] addr,
  output reg_kind_e         kind,
  output logic [REG_AW-1:0] idx
);
  localparam int unsigned BANKS      = (N_LINES + REG_DW - 1) / REG_DW;
  localparam int unsigned PRIO_WORDS = (VEC_BASE + N_LINES + 3) / 4;

  logic [31:0] a32;
  assign a32 = 32'(addr);

  always_comb begin
    kind = RK_NONE;
    idx  = '0;
    if (a32 >= PRIO_BASE && a32 < PRIO_BASE + PRIO_WORDS) begin
      kind = RK_PRIO;
      idx  = REG_AW'(a32 - PRIO_BASE);
    end else if (a32 < PRIO_BASE && (a32 % BANK_STRIDE) < BANKS) begin
      idx = REG_AW'(a32 % BANK_STRIDE);
      case (a32 / BANK_STRIDE)
        32'd0:   kind = RK_EN_SET;
        32'd1:   kind = RK_EN_CLR;
        32'd2:   kind = RK_PD_SET;
        32'd3:   kind = RK_PD_CLR;
        default: kind = RK_NONE;
      endcase
    end
  end
endmodule

// File: rtl/pic_bitbank.sv
module pic_bitbank #(
  parameter int unsigned WIDTH = 64
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] set_bits,
  input  logic [WIDTH-1:0] clr_bits,
  output logic [WIDTH-1:0] state
);
  // a set in the same cycle as a clear wins, so a fresh event is never lost
  always_ff @(posedge clk) begin
    if (rst) state <= '0;
    else     state <= (state & ~clr_bits) | set_bits;
  end
endmodule

// File: rtl/pic_prio_store.sv
module pic_prio_store
  import pic_pkg::*;
#(
  parameter int unsigned N_LINES = 64,
  parameter int unsigned PRIO_W  = 3
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        wr,
  input  logic [REG_AW-1:0]           word_idx,
  input  logic [REG_DW-1:0]           wdata,
  output logic [N_LINES*PRIO_W-1:0]   prio_flat
);
  for (genvar k = 0; k < N_LINES; k++) begin : g_line
    localparam int unsigned VEC  = VEC_BASE + k;
    localparam int unsigned WORD = VEC / 4;
    localparam int unsigned MSB  = 8 * (VEC % 4) + 7;
    logic [PRIO_W-1:0] lvl;
    always_ff @(posedge clk) begin
      if (rst)
        lvl <= '0;
      else if (wr && 32'(word_idx) == WORD)
        lvl <= wdata[MSB -: PRIO_W];
    end
    assign prio_flat[k*PRIO_W +: PRIO_W] = lvl;
  end
endmodule

// File: rtl/pic_arbiter.sv
module pic_arbiter #(
  parameter int unsigned N_LINES = 64,
  parameter int unsigned PRIO_W  = 3,
  localparam int unsigned IDX_W  = (N_LINES > 1) ? $clog2(N_LINES) : 1
) (
  input  logic [N_LINES-1:0]        cand,
  input  logic [N_LINES*PRIO_W-1:0] prio_flat,
  output logic                      found,
  output logic [IDX_W-1:0]          win_idx,
  output logic [PRIO_W-1:0]         win_prio
);
  localparam int unsigned LEAVES = 1 << IDX_W;

  logic              node_v [2*LEAVES];
  logic [PRIO_W-1:0] node_p [2*LEAVES];
  logic [IDX_W-1:0]  node_i [2*LEAVES];

  // binary tournament: left child always holds the lower line numbers,
  // so taking it on equal priority gives the lower-vector tie rule
  always_comb begin
    for (int n = 0; n < 2*LEAVES; n++) begin
      node_v[n] = 1'b0;
      node_p[n] = '0;
      node_i[n] = '0;
    end
    for (int unsigned k = 0; k < LEAVES; k++) begin
      if (k < N_LINES) begin
        node_v[LEAVES+k] = cand[k];
        node_p[LEAVES+k] = prio_flat[k*PRIO_W +: PRIO_W];
      end
      node_i[LEAVES+k] = IDX_W'(k);
    end
    for (int n = LEAVES - 1; n >= 1; n--) begin
      if (node_v[2*n] && (!node_v[2*n+1] || node_p[2*n] <= node_p[2*n+1])) begin
        node_v[n] = node_v[2*n];
        node_p[n] = node_p[2*n];
        node_i[n] = node_i[2*n];
      end else begin
        node_v[n] = node_v[2*n+1];
        node_p[n] = node_p[2*n+1];
        node_i[n] = node_i[2*n+1];
      end
    end
    found    = node_v[1];
    win_idx  = node_i[1];
    win_prio = node_p[1];
  end
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import pic_pkg::*;
#(
  parameter int unsigned N_LINES = 64,
  parameter int unsigned PRIO_W  = 3,
  localparam int unsigned VEC_W  = $clog2(VEC_BASE + N_LINES)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [N_LINES-1:0] irq_in,
  input  logic               reg_wr,
  input  logic [REG_AW-1:0]  reg_addr,
  input  logic [REG_DW-1:0]  reg_wdata,
  output logic [REG_DW-1:0]  reg_rdata,
  input  logic               deliver_hold,
  input  logic               irq_ack,
  output logic               irq_req,
  output logic [VEC_W-1:0]   irq_vec,
  output logic [7:0]         irq_prio
);
  localparam int unsigned IDX_W = (N_LINES > 1) ? $clog2(N_LINES) : 1;
  localparam int unsigned BANKS = (N_LINES + REG_DW - 1) / REG_DW;
  localparam int unsigned PAD_W = BANKS * REG_DW;

  reg_kind_e         kind;
  logic [REG_AW-1:0] idx;

  pic_regdec #(.N_LINES(N_LINES)) u_dec (
    .addr (reg_addr),
    .kind (kind),
    .idx  (idx)
  );

  // write strobes, one full word per bank
  logic [PAD_W-1:0] wr_en_set, wr_en_clr, wr_pd_set, wr_pd_clr;
  always_comb begin
    wr_en_set = '0;
    wr_en_clr = '0;
    wr_pd_set = '0;
    wr_pd_clr = '0;
    for (int unsigned b = 0; b < BANKS; b++) begin
      if (reg_wr && 32'(idx) == b) begin
        case (kind)
          RK_EN_SET: wr_en_set[b*REG_DW +: REG_DW] = reg_wdata;
          RK_EN_CLR: wr_en_clr[b*REG_DW +: REG_DW] = reg_wdata;
          RK_PD_SET: wr_pd_set[b*REG_DW +: REG_DW] = reg_wdata;
          RK_PD_CLR: wr_pd_clr[b*REG_DW +: REG_DW] = reg_wdata;
          default: ;
        endcase
      end
    end
  end

  // edge latching
  logic [N_LINES-1:0] irq_q;
  always_ff @(posedge clk) begin
    if (rst) irq_q <= '0;
    else     irq_q <= irq_in;
  end

  // acknowledge clears the line behind the vector currently presented
  logic [VEC_W-1:0]   vec_off;
  logic [N_LINES-1:0] ack_clr;
  assign vec_off = irq_vec - VEC_W'(VEC_BASE);
  always_comb begin
    ack_clr = '0;
    if (irq_ack && irq_req)
      ack_clr[vec_off[IDX_W-1:0]] = 1'b1;
  end

  logic [N_LINES-1:0] en_q, pend_q;

  pic_bitbank #(.WIDTH(N_LINES)) u_enable (
    .clk      (clk),
    .rst      (rst),
    .set_bits (wr_en_set[N_LINES-1:0]),
    .clr_bits (wr_en_clr[N_LINES-1:0]),
    .state    (en_q)
  );

  pic_bitbank #(.WIDTH(N_LINES)) u_pending (
    .clk      (clk),
    .rst      (rst),
    .set_bits (wr_pd_set[N_LINES-1:0] | (irq_in & ~irq_q)),
    .clr_bits (wr_pd_clr[N_LINES-1:0] | ack_clr),
    .state    (pend_q)
  );

  logic [N_LINES*PRIO_W-1:0] prio_flat;

  pic_prio_store #(.N_LINES(N_LINES), .PRIO_W(PRIO_W)) u_prio (
    .clk       (clk),
    .rst       (rst),
    .wr        (reg_wr && kind == RK_PRIO),
    .word_idx  (idx),
    .wdata     (reg_wdata),
    .prio_flat (prio_flat)
  );

  logic              found;
  logic [IDX_W-1:0]  win_idx;
  logic [PRIO_W-1:0] win_prio;

  pic_arbiter #(.N_LINES(N_LINES), .PRIO_W(PRIO_W)) u_arb (
    .cand      (en_q & pend_q),
    .prio_flat (prio_flat),
    .found     (found),
    .win_idx   (win_idx),
    .win_prio  (win_prio)
  );

  // registered delivery outputs
  always_ff @(posedge clk) begin
    if (rst) begin
      irq_req  <= 1'b0;
      irq_vec  <= '0;
      irq_prio <= '0;
    end else begin
      irq_req  <= found && !deliver_hold && !(irq_ack && irq_req);
      irq_vec  <= found ? VEC_W'(win_idx) + VEC_W'(VEC_BASE) : '0;
      irq_prio <= found ? {win_prio, {(8-PRIO_W){1'b0}}} : '0;
    end
  end

  // read path
  logic [PAD_W-1:0]  en_pad, pd_pad;
  logic [REG_DW-1:0] rd_next;
  assign en_pad = PAD_W'(en_q);
  assign pd_pad = PAD_W'(pend_q);

  always_comb begin
    int unsigned v;
    rd_next = '0;
    v       = 0;
    case (kind)
      RK_EN_SET, RK_EN_CLR: begin
        for (int unsigned b = 0; b < BANKS; b++)
          if (32'(idx) == b) rd_next = en_pad[b*REG_DW +: REG_DW];
      end
      RK_PD_SET, RK_PD_CLR: begin
        for (int unsigned b = 0; b < BANKS; b++)
          if (32'(idx) == b) rd_next = pd_pad[b*REG_DW +: REG_DW];
      end
      RK_PRIO: begin
        for (int unsigned l = 0; l < 4; l++) begin
          v = 32'(idx) * 4 + l;
          if (v >= VEC_BASE && v < VEC_BASE + N_LINES)
            rd_next[8*l +: 8] = {prio_flat[(v-VEC_BASE)*PRIO_W +: PRIO_W],
                                 {(8-PRIO_W){1'b0}}};
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else     reg_rdata <= rd_next;
  end
endmodule

// File: rtl/prio_irq_ctrl_chk.sv
module prio_irq_ctrl_chk #(
  parameter int unsigned N_LINES = 64,
  parameter int unsigned VEC_W   = 7
) (
  input logic               clk,
  input logic               rst,
  input logic               deliver_hold,
  input logic               irq_ack,
  input logic               irq_req,
  input logic [VEC_W-1:0]   irq_vec,
  input logic [N_LINES-1:0] en_bits,
  input logic [N_LINES-1:0] pend_bits
);
  // R10
  hold_blocks_chk: assert property (@(posedge clk) disable iff (rst)
    $past(deliver_hold) |-> !irq_req);

  // R11
  ack_drops_req_chk: assert property (@(posedge clk) disable iff (rst)
    $past(irq_ack && irq_req) |-> !irq_req);

  // R8
  req_has_source_chk: assert property (@(posedge clk) disable iff (rst)
    irq_req |-> $past(|(en_bits & pend_bits)));

  // R5
  vec_in_range_chk: assert property (@(posedge clk) disable iff (rst)
    irq_req |-> (32'(irq_vec) >= 32'd16 && 32'(irq_vec) < 32'd16 + N_LINES));

  // R12
  reset_idle_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!irq_req && irq_vec == '0));
endmodule

bind prio_irq_ctrl prio_irq_ctrl_chk #(.N_LINES(N_LINES), .VEC_W(VEC_W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .deliver_hold (deliver_hold),
  .irq_ack      (irq_ack),
  .irq_req      (irq_req),
  .irq_vec      (irq_vec),
  .en_bits      (en_q),
  .pend_bits    (pend_q)
);

// File: tb/tb_prio_irq_ctrl.sv
module tb_prio_irq_ctrl;
  localparam int unsigned N = 64;
  localparam int unsigned VW = 7;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [N-1:0]  irq_in = '0;
  logic          reg_wr = 1'b0;
  logic [7:0]    reg_addr = '0;
  logic [31:0]   reg_wdata = '0;
  logic [31:0]   reg_rdata;
  logic          deliver_hold = 1'b0;
  logic          irq_ack = 1'b0;
  logic          irq_req;
  logic [VW-1:0] irq_vec;
  logic [7:0]    irq_prio;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;
  logic [31:0] pshadow [20];

  always #2 clk = ~clk;

  prio_irq_ctrl #(.N_LINES(N), .PRIO_W(3)) dut (
    .clk(clk), .rst(rst), .irq_in(irq_in), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .deliver_hold(deliver_hold),
    .irq_ack(irq_ack), .irq_req(irq_req), .irq_vec(irq_vec), .irq_prio(irq_prio)
  );

  // {req[3:0], op[1:0] (0 write, 1 read-check), addr[7:0], data[31:0]}
  localparam int TBL_N = 22;
  localparam logic [45:0] TBL [TBL_N] = '{
    {4'd1, 2'd0, 8'h00, 32'h0000_0005},
    {4'd1, 2'd1, 8'h00, 32'h0000_0005},   // R1 set takes effect
    {4'd3, 2'd1, 8'h08, 32'h0000_0005},   // R3 clear bank reads state
    {4'd2, 2'd0, 8'h08, 32'h0000_0001},
    {4'd2, 2'd1, 8'h00, 32'h0000_0004},   // R2 only bit 0 cleared
    {4'd1, 2'd0, 8'h00, 32'h0000_0000},
    {4'd1, 2'd1, 8'h00, 32'h0000_0004},   // R1 zero write ignored
    {4'd2, 2'd0, 8'h08, 32'h0000_0000},
    {4'd2, 2'd1, 8'h08, 32'h0000_0004},   // R2 zero write ignored
    {4'd3, 2'd0, 8'h11, 32'h8000_0000},
    {4'd3, 2'd1, 8'h19, 32'h8000_0000},   // R3 line 63 pending
    {4'd3, 2'd1, 8'h11, 32'h8000_0000},
    {4'd3, 2'd1, 8'h10, 32'h0000_0000},
    {4'd3, 2'd0, 8'h19, 32'h8000_0000},
    {4'd3, 2'd1, 8'h11, 32'h0000_0000},   // R3 pending cleared
    {4'd6, 2'd0, 8'h24, 32'hFFFF_FFFF},
    {4'd6, 2'd1, 8'h24, 32'hE0E0_E0E0},   // R6 low bits dropped
    {4'd6, 2'd0, 8'h20, 32'hFFFF_FFFF},
    {4'd6, 2'd1, 8'h20, 32'h0000_0000},   // R6 reserved vectors
    {4'd6, 2'd0, 8'h24, 32'h0000_0000},
    {4'd6, 2'd1, 8'h24, 32'h0000_0000},
    {4'd6, 2'd1, 8'h34, 32'h0000_0000}    // R6 beyond last word
  };

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(string tag, logic [7:0] a, logic [31:0] exp);
    reg_addr = a;
    @(negedge clk);
    chk(tag, reg_rdata, exp);
  endtask

  task automatic pulse(int k);
    irq_in[k] = 1'b1;
    @(negedge clk);
    irq_in[k] = 1'b0;
  endtask

  task automatic ack_once();
    irq_ack = 1'b1;
    @(negedge clk);
    irq_ack = 1'b0;
  endtask

  task automatic set_pb(int vec, logic [7:0] b);
    pshadow[vec/4][8*(vec%4) +: 8] = b;
    wr(8'(32 + vec/4), pshadow[vec/4]);
  endtask

  task automatic out_chk(string tag, logic req, int vec, logic [7:0] pr);
    chk({tag, " req"}, 32'(irq_req), 32'(req));
    if (req) begin
      chk({tag, " vec"}, 32'(irq_vec), 32'(vec));
      chk({tag, " prio"}, 32'(irq_prio), 32'(pr));
    end
  endtask

  initial begin
    for (int w = 0; w < 20; w++) pshadow[w] = '0;
    tick(3);
    rst = 1'b0;
    tick(1);
    // R12 reset state
    chk("R12 req after reset", 32'(irq_req), 32'd0);
    chk("R12 vec after reset", 32'(irq_vec), 32'd0);
    rd("R12 enable bank0", 8'h00, 32'h0);
    rd("R12 pending bank1", 8'h11, 32'h0);
    rd("R12 prio word", 8'h2A, 32'h0);

    for (int i = 0; i < TBL_N; i++) begin
      if (TBL[i][41:40] == 2'd0) wr(TBL[i][39:32], TBL[i][31:0]);
      else rd($sformatf("R%0d table row %0d", TBL[i][45:42], i), TBL[i][39:32], TBL[i][31:0]);
    end

    // R4 R5 single line delivered as vector k+16
    wr(8'h00, 32'h0000_0008);
    pulse(3);
    tick(2);
    out_chk("R5 line3", 1'b1, 19, 8'h00);
    // R11 ack
    ack_once();
    chk("R11 req drops after ack", 32'(irq_req), 32'd0);
    tick(2);
    chk("R11 no redelivery", 32'(irq_req), 32'd0);
    rd("R11 pending cleared", 8'h10, 32'h0);

    // R4 held-high line latches once
    irq_in[7] = 1'b1;
    tick(2);
    rd("R4 edge sets pending", 8'h10, 32'h0000_0080);
    wr(8'h18, 32'h0000_0080);
    tick(2);
    rd("R4 held line no relatch", 8'h10, 32'h0);
    irq_in[7] = 1'b0;

    // R7 priority order
    set_pb(26, 8'h40);
    set_pb(56, 8'h20);
    wr(8'h00, 32'h0000_0400);
    wr(8'h01, 32'h0000_0100);
    irq_in[10] = 1'b1; irq_in[40] = 1'b1;
    tick(1);
    irq_in[10] = 1'b0; irq_in[40] = 1'b0;
    tick(2);
    out_chk("R7 smaller prio wins", 1'b1, 56, 8'h20);
    ack_once();
    tick(2);
    out_chk("R7 next winner", 1'b1, 26, 8'h40);
    ack_once();
    tick(2);
    chk("R11 all served", 32'(irq_req), 32'd0);

    // R6 R7 tie, low bits ignored
    set_pb(25, 8'h7F);
    set_pb(36, 8'h60);
    rd("R6 truncated byte", 8'h26, 32'h0040_6000);
    wr(8'h00, 32'h0010_0200);
    irq_in[9] = 1'b1; irq_in[20] = 1'b1;
    tick(1);
    irq_in[9] = 1'b0; irq_in[20] = 1'b0;
    tick(2);
    out_chk("R7 tie lower vector", 1'b1, 25, 8'h60);
    ack_once();
    tick(2);
    out_chk("R7 tie second", 1'b1, 36, 8'h60);
    ack_once();
    tick(2);

    // R8 pending while disabled
    pulse(50);
    tick(2);
    chk("R8 disabled not delivered", 32'(irq_req), 32'd0);
    rd("R8 stays pending", 8'h11, 32'h0004_0000);
    wr(8'h01, 32'h0004_0000);
    tick(2);
    out_chk("R8 delivered on enable", 1'b1, 66, 8'h00);

    // R10 hold
    deliver_hold = 1'b1;
    tick(2);
    chk("R10 hold blocks", 32'(irq_req), 32'd0);
    rd("R10 enables kept", 8'h01, 32'h0004_0100);
    deliver_hold = 1'b0;
    tick(2);
    out_chk("R10 released", 1'b1, 66, 8'h00);
    ack_once();
    tick(2);

    // R9 clear discards
    pulse(1);
    wr(8'h18, 32'h0000_0002);
    wr(8'h00, 32'h0000_0002);
    tick(2);
    chk("R9 discarded", 32'(irq_req), 32'd0);
    rd("R9 pending empty", 8'h10, 32'h0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog (all): actual hung expected finished");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule